// File: doc/BRIEF.md
# Pin-Multiplexed GPIO Bank

This block is a bank of four general-purpose I/O ports that sit on the byte-wide bus of an 8-bit processor. Three ports are eight pins wide and the fourth has three pins. Each pin is configured on its own. It can stay an input, or drive one of three sources: a bit that software writes, a bit of the latched bus address, or a chip-select line from a programmable logic array. Each pin's output-enable comes from a direction bit. The pad level is synchronised into a pin-input register whatever the direction is.

The processor reaches the bank through a 16-byte window. Each port has four bytes: pin input (read-only), output-select control, output data and direction. The output-select control register exists only on the two lower ports. On the two upper ports, each pin's choice between the data bit and the logic-array line is fixed by a build-time parameter. One combinational readback selector puts exactly one register on the read bus at a time, so software can check every value it wrote. The address latch and the logic array are outside the block and arrive as plain input vectors.

Top module: `gpio_mux_bank`

## Requirements
- R1: While `rst_n` is low, and after reset, every register reads 0 and `pad_oe` is all zero, so every pin starts as an input.
- R2: Byte offset 2 (output data) and offset 3 (direction) of port p (base address 4*p, p = 0..3) read back the last value written. The upper five bits of port 3 always read 0.
- R3: Offset 1 (output-select control) of ports 0 and 1 reads back the written value. Offset 1 of ports 2 and 3 always reads 0, and writing it changes no `pad_out` bit.
- R4: `pad_oe` bit i equals direction bit i of its port: 1 drives the pin, 0 leaves it high-impedance. Pins of port p occupy `pad_*[8p +: width]`.
- R5: On ports 0 and 1, a control bit of 0 drives the output-data bit and a control bit of 1 drives the latched address bit. Port 0 uses `lat_addr[7:0]` and port 1 uses `lat_addr[15:8]`.
- R6: On ports 2 and 3, a set bit of the static select parameter (`SEL_C`, `SEL_D`, defaults 8'hF0 and 3'b101) drives `pld_cs` (port 2 uses `pld_cs[7:0]`, port 3 uses `pld_cs[10:8]`). A clear bit drives the output-data bit.
- R7: Offset 0 reads the pad level, whatever the direction. A change on `pad_in` appears there after the third rising clock edge (two synchroniser flops, then the register). Writes to offset 0 have no effect.
- R8: A register changes only on a rising edge where `bus_cs` and `bus_wr` are both 1.
- R9: `bus_rdata` is 0 unless `bus_cs` and `bus_rd` are both 1. When both are 1, it shows the register at `bus_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_cs | input | 1 | Chip-select for the I/O window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address: port in [3:2], register in [1:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| lat_addr | input | 16 | Latched address bits for ports 0 and 1 |
| pld_cs | input | 11 | Logic-array chip-select lines for ports 2 and 3 |
| pad_in | input | 27 | Pad input levels |
| pad_out | output | 27 | Pad output values |
| pad_oe | output | 27 | Pad output enables |

## Verification
The assertions check on every cycle that the read bus is quiet when no read is active and that the upper bits of port 3 read 0. They also check that output enables move only after a write cycle, that the statically selected pins of port 2 follow the logic-array lines, and that outputs are cleared while in reset. Only the bench scenarios show that written values come back at the right offsets and that the control register steers each pin between its data bit and its address bit. The same holds for the three-edge latency of the pin input and for writes that must have no effect.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NPORT  = 4;
  localparam int NREG   = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = $clog2(NPORT * NREG);

  typedef enum logic [1:0] {
    OFF_PIN  = 2'd0,
    OFF_CTRL = 2'd1,
    OFF_DOUT = 2'd2,
    OFF_DIR  = 2'd3
  } reg_off_e;
endpackage

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
  parameter int              W          = 8,
  parameter bit              HAS_CTRL   = 1'b1,
  parameter logic [W-1:0]    STATIC_SEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_ctrl,
  input  logic         we_dout,
  input  logic         we_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] alt_i,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] dout_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] pin_q
);
  logic [W-1:0] dout_d, dir_d;
  logic [W-1:0] sync1_q, sync2_q;
  logic [W-1:0] sel;

  // next-state
  always_comb begin
    dout_d = dout_q;
    dir_d  = dir_q;
    if (we_dout) dout_d = wdata;
    if (we_dir)  dir_d  = wdata;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      if (we_dout) dout_q <= dout_d;
      if (we_dir)  dir_q  <= dir_d;
    end
  end

  // pad synchroniser and pin-input register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      pin_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      pin_q   <= sync2_q;
    end
  end

  generate
    if (HAS_CTRL) begin : g_ctrl
      logic [W-1:0] ctrl_d;
      always_comb ctrl_d = we_ctrl ? wdata : ctrl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (we_ctrl) ctrl_q <= ctrl_d;
      end
      assign sel = ctrl_q;
    end else begin : g_static
      logic unused_we_ctrl;
      assign unused_we_ctrl = we_ctrl;
      assign ctrl_q = '0;
      assign sel    = STATIC_SEL;
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < W; i++) begin
      pad_out[i] = sel[i] ? alt_i[i] : dout_q[i];
    end
  end

  assign pad_oe = dir_q;
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_bank_pkg::*;
#(
  parameter int NSRC = NPORT * NREG
) (
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NSRC*DATA_W-1:0] src,
  output logic [DATA_W-1:0]      rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) rdata = src[addr*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_bank_pkg::*;
#(
  parameter int                  PORT_W   = 8,
  parameter int                  NARROW_W = 3,
  parameter logic [PORT_W-1:0]   SEL_C    = 8'hF0,
  parameter logic [NARROW_W-1:0] SEL_D    = 3'b101
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_cs,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [3:0]                     bus_addr,
  input  logic [7:0]                     bus_wdata,
  output logic [7:0]                     bus_rdata,
  input  logic [2*PORT_W-1:0]            lat_addr,
  input  logic [PORT_W+NARROW_W-1:0]     pld_cs,
  input  logic [3*PORT_W+NARROW_W-1:0]   pad_in,
  output logic [3*PORT_W+NARROW_W-1:0]   pad_out,
  output logic [3*PORT_W+NARROW_W-1:0]   pad_oe
);
  localparam int NSRC = NPORT * NREG;

  logic rst_s1_q, rst_s2_q;
  logic wr_en, rd_en;
  logic [1:0] port_idx;
  logic [1:0] reg_off;
  logic [NSRC*DATA_W-1:0] rb_src;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign wr_en    = bus_cs & bus_wr;
  assign rd_en    = bus_cs & bus_rd;
  assign port_idx = bus_addr[3:2];
  assign reg_off  = bus_addr[1:0];

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      localparam int W    = (p == NPORT - 1) ? NARROW_W : PORT_W;
      localparam int BASE = p * PORT_W;
      localparam logic [W-1:0] SSEL = (p == 2) ? W'(SEL_C) :
                                      (p == 3) ? W'(SEL_D) : '0;
      logic [W-1:0] alt, ctrl_q, dout_q, dir_q, pin_q;
      logic hit;

      if (p < 2) begin : g_addr_src
        assign alt = lat_addr[p*PORT_W +: W];
      end else begin : g_pld_src
        assign alt = pld_cs[(p-2)*PORT_W +: W];
      end

      assign hit = wr_en && (port_idx == 2'(p));

      gpio_port_slice #(
        .W          (W),
        .HAS_CTRL   (p < 2),
        .STATIC_SEL (SSEL)
      ) u_slice (
        .clk     (clk),
        .rst_n   (rst_s2_q),
        .we_ctrl (hit && reg_off == OFF_CTRL),
        .we_dout (hit && reg_off == OFF_DOUT),
        .we_dir  (hit && reg_off == OFF_DIR),
        .wdata   (bus_wdata[W-1:0]),
        .alt_i   (alt),
        .pad_in  (pad_in[BASE +: W]),
        .pad_out (pad_out[BASE +: W]),
        .pad_oe  (pad_oe[BASE +: W]),
        .ctrl_q  (ctrl_q),
        .dout_q  (dout_q),
        .dir_q   (dir_q),
        .pin_q   (pin_q)
      );

      assign rb_src[(p*NREG + OFF_PIN )*DATA_W +: DATA_W] = DATA_W'(pin_q);
      assign rb_src[(p*NREG + OFF_CTRL)*DATA_W +: DATA_W] = DATA_W'(ctrl_q);
      assign rb_src[(p*NREG + OFF_DOUT)*DATA_W +: DATA_W] = DATA_W'(dout_q);
      assign rb_src[(p*NREG + OFF_DIR )*DATA_W +: DATA_W] = DATA_W'(dir_q);
    end
  endgenerate

  gpio_readback #(.NSRC(NSRC)) u_rb (
    .rd_en (rd_en),
    .addr  (bus_addr),
    .src   (rb_src),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk #(
  parameter int                  PORT_W   = 8,
  parameter int                  NARROW_W = 3,
  parameter logic [PORT_W-1:0]   SEL_C    = 8'hF0,
  parameter logic [NARROW_W-1:0] SEL_D    = 3'b101
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_cs,
  input logic                         bus_wr,
  input logic                         bus_rd,
  input logic [3:0]                   bus_addr,
  input logic [7:0]                   bus_wdata,
  input logic [7:0]                   bus_rdata,
  input logic [2*PORT_W-1:0]          lat_addr,
  input logic [PORT_W+NARROW_W-1:0]   pld_cs,
  input logic [3*PORT_W+NARROW_W-1:0] pad_in,
  input logic [3*PORT_W+NARROW_W-1:0] pad_out,
  input logic [3*PORT_W+NARROW_W-1:0] pad_oe
);
  // R1: outputs are disabled while reset is held
  a_r1_reset_oe: assert property (@(posedge clk)
    !rst_n |-> pad_oe == '0);

  // R9: quiet read bus without an active read
  a_r9_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_rd) |-> bus_rdata == '0);

  // R2: unused upper bits of the narrow port read as zero
  a_r2_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_rd && bus_addr[3:2] == 2'd3) |-> bus_rdata[7:NARROW_W] == '0);

  // R8 / R4: enables change only after a write cycle
  a_r8_oe_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_oe) |-> $past(bus_cs && bus_wr));

  // R6: statically selected pins of port 2 follow the logic-array lines
  a_r6_static_sel: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out[2*PORT_W +: PORT_W] ^ pld_cs[PORT_W-1:0]) & SEL_C) == '0);

  // R6: same for the narrow port
  a_r6_static_sel_d: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out[3*PORT_W +: NARROW_W] ^ pld_cs[PORT_W +: NARROW_W]) & SEL_D) == '0);

  logic unused_chk;
  assign unused_chk = ^{bus_wdata, lat_addr, pad_in};
endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(
  .PORT_W(PORT_W), .NARROW_W(NARROW_W), .SEL_C(SEL_C), .SEL_D(SEL_D)
) u_chk (.*);

// File: tb/sim_gpio_mux_bank.sv
module sim_gpio_mux_bank;
  localparam logic [7:0] SEL_C = 8'hF0;
  localparam logic [2:0] SEL_D = 3'b101;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_cs, bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] lat_addr;
  logic [10:0] pld_cs;
  logic [26:0] pad_in, pad_out, pad_oe;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  gpio_mux_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lat_addr(lat_addr), .pld_cs(pld_cs), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d,
                           input logic cs = 1'b1, input logic wr = 1'b1);
    @(negedge clk);
    bus_cs = cs; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_cs = 1'b0; bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] pmask(input int p);
    return (p == 3) ? 8'h07 : 8'hFF;
  endfunction

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [26:0] snap;
    rst_n = 1'b0; bus_cs = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    lat_addr = 0; pld_cs = 0; pad_in = 0;
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", 32'(pad_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of every register and pin
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 out", 32'(pad_out), 0);
    for (int a = 0; a < 16; a++) begin
      bus_read(4'(a), rd);
      chk("R1 reg", 32'(rd), 0);
    end

    // R9: no read strobe or no chip-select gives zero
    bus_write(4'd2, 8'h5A);
    @(negedge clk); bus_cs = 1; bus_rd = 0; bus_addr = 4'd2; #1;
    chk("R9 rd low", 32'(bus_rdata), 0);
    bus_cs = 0; bus_rd = 1; #1;
    chk("R9 cs low", 32'(bus_rdata), 0);
    bus_rd = 0;

    // R2, R3, R4: sweep output data, direction and control on every port
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 256; v++) begin
        bus_write(4'(p*4 + 2), 8'(v));
        bus_read(4'(p*4 + 2), rd);
        chk("R2 dout readback", 32'(rd), 32'(8'(v) & pmask(p)));
        bus_write(4'(p*4 + 3), 8'(v));
        bus_read(4'(p*4 + 3), rd);
        chk("R2 dir readback", 32'(rd), 32'(8'(v) & pmask(p)));
        chk("R4 oe follows dir", 32'(pad_oe[p*8 +: 3]), 32'(v & 7));
        if (p < 3) chk("R4 oe byte", 32'(pad_oe[p*8 +: 8]), 32'(v));
        bus_write(4'(p*4 + 1), 8'(v));
        bus_read(4'(p*4 + 1), rd);
        chk("R3 ctrl readback", 32'(rd), (p < 2) ? 32'(v) : 0);
      end
    end

    // R5: control steers ports 0 and 1 between data and latched address
    lat_addr = 16'hA55A;
    bus_write(4'd2, 8'h3C);
    bus_write(4'd6, 8'hC3);
    for (int c = 0; c < 256; c++) begin
      bus_write(4'd1, 8'(c));
      bus_write(4'd5, 8'(c));
      chk("R5 port0 mux", 32'(pad_out[7:0]), 32'((8'h5A & 8'(c)) | (8'h3C & ~8'(c))));
      chk("R5 port1 mux", 32'(pad_out[15:8]), 32'((8'hA5 & 8'(c)) | (8'hC3 & ~8'(c))));
    end

    // R6: static selection on ports 2 and 3
    bus_write(4'd10, 8'hAA);
    bus_write(4'd14, 8'h02);
    for (int k = 0; k < 64; k++) begin
      pld_cs = 11'(k * 37 + 5);
      #1;
      chk("R6 port2", 32'(pad_out[23:16]), 32'((pld_cs[7:0] & SEL_C) | (8'hAA & ~SEL_C)));
      chk("R6 port3", 32'(pad_out[26:24]), 32'((pld_cs[10:8] & SEL_D) | (3'b010 & ~SEL_D)));
    end

    // R3: control writes on ports 2 and 3 have no effect on pins
    snap = pad_out;
    bus_write(4'd9, 8'hFF);
    bus_write(4'd13, 8'hFF);
    chk("R3 no-ctrl port2 pins", 32'(pad_out), 32'(snap));
    bus_read(4'd9, rd);
    chk("R3 no-ctrl reads 0", 32'(rd), 0);

    // R7: pin input latency and independence from direction
    bus_write(4'd3, 8'hFF);
    @(negedge clk); pad_in = 27'h5A5_A5A5;
    @(posedge clk); @(posedge clk); #1;
    bus_cs = 1; bus_rd = 1; bus_addr = 4'd0; #1;
    chk("R7 not yet after 2 edges", 32'(bus_rdata), 0);
    bus_cs = 0; bus_rd = 0;
    @(posedge clk); #1;
    bus_cs = 1; bus_rd = 1; bus_addr = 4'd0; #1;
    chk("R7 visible after 3 edges", 32'(bus_rdata), 32'h A5);
    bus_cs = 0; bus_rd = 0;
    for (int p = 0; p < 4; p++) begin
      bus_read(4'(p*4), rd);
      chk("R7 pin read", 32'(rd), 32'(pad_in[p*8 +: 8] & pmask(p)));
    end
    bus_write(4'd0, 8'h00);
    bus_read(4'd0, rd);
    chk("R7 write to pin ignored", 32'(rd), 32'h A5);

    // R8: a strobe alone does not write
    bus_write(4'd2, 8'h11);
    bus_write(4'd2, 8'h99, 1'b1, 1'b0);
    bus_read(4'd2, rd);
    chk("R8 cs without wr", 32'(rd), 32'h11);
    bus_write(4'd2, 8'h77, 1'b0, 1'b1);
    bus_read(4'd2, rd);
    chk("R8 wr without cs", 32'(rd), 32'h11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule